// File: doc/BRIEF.md
# Inhibit-Guarded Angle Output Latch

This block sits between a tracking angle counter and a host bus. It holds a copy of the counter word that the host can read as two separately driven bytes without tearing, while the counter keeps moving. The counter announces each update with a busy pulse. The block takes the live word into a counter image a set number of clock edges into that pulse. An output latch follows the image only while busy is low and no hold is in force.

The host pulls the active-low inhibit input low to freeze the output word. It waits for the data-valid flag, which rises after a set number of settling cycles, then reads the high and low bytes through their own active-low enables, and finally releases inhibit. An inhibit that arrives during a busy pulse does not freeze the word at once. The block first lets that update through and freezes the word when busy goes low. Each byte bus is modelled as a data value plus an output enable. A bus that is not enabled reads as zero.

The control path is a four-state machine: TRACK, PEND, SETTLE and HELD. The transitions are:
- TRACK to PEND when inhibit is low while busy is high.
- TRACK to SETTLE when inhibit is low while busy is low.
- PEND to SETTLE when busy falls.
- SETTLE to HELD when the settle count expires.
- Any state to TRACK when inhibit is high.

Top module: `angle_hold_latch`

## Requirements
- R1: After reset the held word is 0x0000, `data_valid` is 0, and with both enables high both `hi_oe` and `lo_oe` are 0 and both byte buses read 0x00.
- R2: In TRACK with busy low, the held word loads the counter image on every clock edge. A new word is visible on the byte buses by the second clock edge after busy is sampled low.
- R3: The counter image takes `angle_in` only at the UPD_DLY-th rising edge at which `busy_in` is sampled high (default 3). Changes of `angle_in` at any other time have no effect on the output. Busy pulses last at least UPD_DLY edges.
- R4: While `busy_in` is high the held word does not change.
- R5: When inhibit is sampled low while busy is low, the machine goes TRACK to SETTLE and the word freezes at that edge. It stays frozen through SETTLE and HELD whatever busy does, until inhibit is released.
- R6: When inhibit is sampled low while busy is high, the machine goes TRACK to PEND and the word is not frozen yet. At the first edge with busy low it takes the updated image and moves PEND to SETTLE.
- R7: `data_valid` is 1 only in HELD. HELD is entered exactly SETTLE_CYC edges (default 25) after the edge that entered SETTLE. `data_valid` clears on the edge at which inhibit is sampled high.
- R8: `hi_en_n` low gives `hi_oe`=1 and `hi_byte` = held word bits 15:8. `hi_en_n` high gives `hi_oe`=0 and `hi_byte`=0x00.
- R9: `lo_en_n` low gives `lo_oe`=1 and `lo_byte` = held word bits 7:0. `lo_en_n` high gives `lo_oe`=0 and `lo_byte`=0x00. This is independent of the high byte.
- R10: After inhibit is released the machine returns to TRACK. The held word catches up with the counter image on the next edge with busy low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| angle_in | input | 16 | Live tracking counter word |
| busy_in | input | 1 | Converter busy pulse, high during a counter update |
| inhibit_n | input | 1 | Active-low hold request from the host |
| hi_en_n | input | 1 | Active-low enable for the high byte bus |
| lo_en_n | input | 1 | Active-low enable for the low byte bus |
| hi_byte | output | 8 | High byte data (0 when not enabled) |
| hi_oe | output | 1 | High byte output enable |
| lo_byte | output | 8 | Low byte data (0 when not enabled) |
| lo_oe | output | 1 | Low byte output enable |
| data_valid | output | 1 | Held word has settled and may be read |

## Verification
The assertions take for granted the following about the inputs:
- All inputs are synchronous to `clk`.
- Every busy pulse stays high for at least UPD_DLY edges, so each pulse delivers exactly one image update.
- Inhibit is a level that the host holds for as long as the read takes.

The stimulus changes every input on the falling clock edge. Every busy pulse lasts five edges. Inhibit is lowered either with busy idle or one cycle into a pulse, which reaches both the SETTLE and the PEND entry paths.

// File: rtl/angle_hold_pkg.sv
package angle_hold_pkg;
    typedef enum logic [1:0] {
        ST_TRACK  = 2'd0,
        ST_PEND   = 2'd1,
        ST_SETTLE = 2'd2,
        ST_HELD   = 2'd3
    } hold_state_e;
endpackage

// File: rtl/busy_tracker.sv
module busy_tracker #(
    parameter int W       = 16,
    parameter int UPD_DLY = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         busy_in,
    input  logic [W-1:0] angle_in,
    output logic [W-1:0] img_o
);
    localparam int CW = $clog2(UPD_DLY + 1);
    localparam logic [CW-1:0] LAST = CW'(UPD_DLY - 1);
    localparam logic [CW-1:0] FULL = CW'(UPD_DLY);

    logic [CW-1:0] bcnt;
    logic          take;

    // the image is loaded once, at the UPD_DLY-th busy-high edge
    assign take = busy_in && (bcnt == LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bcnt <= '0;
        end else if (!busy_in) begin
            bcnt <= '0;
        end else if (bcnt != FULL) begin
            bcnt <= bcnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            img_o <= '0;
        end else if (take) begin
            img_o <= angle_in;
        end
    end

    // R3
    img_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_in |=> $stable(img_o));
endmodule

// File: rtl/inhibit_fsm.sv
module inhibit_fsm
    import angle_hold_pkg::*;
#(
    parameter int SETTLE_CYC = 25
) (
    input  logic clk,
    input  logic rst_n,
    input  logic busy_in,
    input  logic inhibit_n,
    output logic open_o,
    output logic frozen_o,
    output logic valid_o
);
    localparam int SCW = $clog2(SETTLE_CYC + 1);
    localparam logic [SCW-1:0] SLAST = SCW'(SETTLE_CYC - 1);

    hold_state_e state, nxt;
    logic [SCW-1:0] scnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_TRACK;
        end else begin
            state <= nxt;
        end
    end

    always_comb begin
        nxt = state;
        unique case (state)
            ST_TRACK: begin
                if (!inhibit_n) nxt = busy_in ? ST_PEND : ST_SETTLE;
            end
            ST_PEND: begin
                if (inhibit_n)     nxt = ST_TRACK;
                else if (!busy_in) nxt = ST_SETTLE;
            end
            ST_SETTLE: begin
                if (inhibit_n)           nxt = ST_TRACK;
                else if (scnt == SLAST)  nxt = ST_HELD;
            end
            ST_HELD: begin
                if (inhibit_n) nxt = ST_TRACK;
            end
            default: nxt = ST_TRACK;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scnt <= '0;
        end else if (state != ST_SETTLE) begin
            scnt <= '0;
        end else if (scnt != SLAST) begin
            scnt <= scnt + 1'b1;
        end
    end

    always_comb begin
        open_o   = 1'b0;
        frozen_o = 1'b0;
        valid_o  = 1'b0;
        unique case (state)
            ST_TRACK:  open_o = !busy_in;
            ST_PEND:   open_o = !busy_in;
            ST_SETTLE: frozen_o = 1'b1;
            ST_HELD: begin
                frozen_o = 1'b1;
                valid_o  = 1'b1;
            end
            default: open_o = 1'b0;
        endcase
    end

    // R7
    valid_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        inhibit_n |=> !valid_o);
    // R7
    valid_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(valid_o) |-> !$past(inhibit_n));
    // R6
    pend_defer_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_TRACK && !inhibit_n && busy_in) |=> !frozen_o);
endmodule

// File: rtl/byte_drive.sv
module byte_drive #(
    parameter int BW = 8
) (
    input  logic          en_n,
    input  logic [BW-1:0] word_byte,
    output logic          oe,
    output logic [BW-1:0] bus
);
    always_comb begin
        oe  = !en_n;
        bus = oe ? word_byte : '0;
    end
endmodule

// File: rtl/angle_hold_latch.sv
module angle_hold_latch #(
    parameter int W          = 16,
    parameter int UPD_DLY    = 3,
    parameter int SETTLE_CYC = 25
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [15:0] angle_in,
    input  logic        busy_in,
    input  logic        inhibit_n,
    input  logic        hi_en_n,
    input  logic        lo_en_n,
    output logic [7:0]  hi_byte,
    output logic        hi_oe,
    output logic [7:0]  lo_byte,
    output logic        lo_oe,
    output logic        data_valid
);
    localparam int BW     = 8;
    localparam int NLANES = 2;

    logic [W-1:0] img;
    logic [W-1:0] held;
    logic         open_s, frozen_s;
    logic [NLANES-1:0]         lane_en_n;
    logic [NLANES-1:0]         lane_oe;
    logic [NLANES-1:0][BW-1:0] lane_bus;

    busy_tracker #(.W(W), .UPD_DLY(UPD_DLY)) trk_i (
        .clk(clk), .rst_n(rst_n), .busy_in(busy_in),
        .angle_in(angle_in), .img_o(img)
    );

    inhibit_fsm #(.SETTLE_CYC(SETTLE_CYC)) fsm_i (
        .clk(clk), .rst_n(rst_n), .busy_in(busy_in), .inhibit_n(inhibit_n),
        .open_o(open_s), .frozen_o(frozen_s), .valid_o(data_valid)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            held <= '0;
        end else if (open_s) begin
            held <= img;
        end
    end

    assign lane_en_n = {hi_en_n, lo_en_n};

    for (genvar g = 0; g < NLANES; g++) begin : g_lane
        byte_drive #(.BW(BW)) drv_i (
            .en_n(lane_en_n[g]),
            .word_byte(held[g*BW +: BW]),
            .oe(lane_oe[g]),
            .bus(lane_bus[g])
        );
    end

    assign hi_oe   = lane_oe[1];
    assign hi_byte = lane_bus[1];
    assign lo_oe   = lane_oe[0];
    assign lo_byte = lane_bus[0];

    // R4
    busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy_in |=> $stable(held));
    // R5
    freeze_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frozen_s |=> $stable(held));
    // R8
    hi_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hi_en_n |-> (!hi_oe && hi_byte == 8'h00));
endmodule

// File: tb/angle_hold_latch_tb_top.sv
module angle_hold_latch_tb_top;
    localparam int UPD = 3;
    localparam int SET = 25;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] angle_in = 16'h0;
    logic        busy_in = 1'b0;
    logic        inhibit_n = 1'b1;
    logic        hi_en_n = 1'b1;
    logic        lo_en_n = 1'b1;
    logic [7:0]  hi_byte, lo_byte;
    logic        hi_oe, lo_oe, data_valid;
    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    angle_hold_latch #(.UPD_DLY(UPD), .SETTLE_CYC(SET)) dut_i (
        .clk(clk), .rst_n(rst_n), .angle_in(angle_in), .busy_in(busy_in),
        .inhibit_n(inhibit_n), .hi_en_n(hi_en_n), .lo_en_n(lo_en_n),
        .hi_byte(hi_byte), .hi_oe(hi_oe), .lo_byte(lo_byte), .lo_oe(lo_oe),
        .data_valid(data_valid)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic read_word(input string req, input logic [15:0] exp);
        hi_en_n = 1'b0;
        lo_en_n = 1'b0;
        #1;
        chk(req, {hi_byte, lo_byte}, exp);
        hi_en_n = 1'b1;
        lo_en_n = 1'b1;
    endtask

    task automatic busy_pulse(input logic [15:0] a);
        @(negedge clk);
        angle_in = a;
        busy_in  = 1'b1;
        repeat (5) @(negedge clk);
        busy_in  = 1'b0;
        angle_in = ~a;
        repeat (2) @(negedge clk);
    endtask

    task automatic t_reset();
        chk("R1 hi_oe", hi_oe, 0);
        chk("R1 lo_oe", lo_oe, 0);
        chk("R1 valid", data_valid, 0);
        chk("R1 buses off", {hi_byte, lo_byte}, 0);
        read_word("R1 word", 16'h0000);
    endtask

    task automatic t_track();
        busy_pulse(16'h1234);
        read_word("R2 R3 tracked word", 16'h1234);
        angle_in = 16'hFFFF;
        repeat (4) @(negedge clk);
        read_word("R3 no busy ignored", 16'h1234);
    endtask

    task automatic t_busy_hold();
        @(negedge clk);
        angle_in = 16'hABCD;
        busy_in  = 1'b1;
        repeat (4) @(negedge clk);
        read_word("R4 held during busy", 16'h1234);
        @(negedge clk);
        busy_in = 1'b0;
        repeat (2) @(negedge clk);
        read_word("R2 after busy", 16'hABCD);
    endtask

    task automatic t_inhibit_idle();
        @(negedge clk);
        inhibit_n = 1'b0;
        repeat (SET) @(negedge clk);
        chk("R7 not yet valid", data_valid, 0);
        @(negedge clk);
        chk("R7 valid at settle", data_valid, 1);
        busy_pulse(16'h5555);
        read_word("R5 frozen through busy", 16'hABCD);
        chk("R7 still valid", data_valid, 1);
        inhibit_n = 1'b1;
        @(negedge clk);
        chk("R7 valid cleared", data_valid, 0);
        @(negedge clk);
        read_word("R10 catch up", 16'h5555);
    endtask

    task automatic t_inhibit_busy();
        @(negedge clk);
        angle_in = 16'h9999;
        busy_in  = 1'b1;
        @(negedge clk);
        inhibit_n = 1'b0;
        repeat (4) @(negedge clk);
        busy_in = 1'b0;
        angle_in = 16'h0;
        repeat (2) @(negedge clk);
        read_word("R6 update let through", 16'h9999);
        busy_pulse(16'h7777);
        read_word("R6 R5 frozen after", 16'h9999);
        repeat (SET) @(negedge clk);
        chk("R7 valid after pend", data_valid, 1);
        inhibit_n = 1'b1;
        repeat (2) @(negedge clk);
        read_word("R10 released", 16'h7777);
    endtask

    task automatic t_bytes();
        hi_en_n = 1'b0;
        lo_en_n = 1'b1;
        #1;
        chk("R8 hi_oe on", hi_oe, 1);
        chk("R8 hi byte", hi_byte, 8'h77);
        chk("R9 lo off", {lo_oe, lo_byte}, 0);
        hi_en_n = 1'b1;
        lo_en_n = 1'b0;
        #1;
        chk("R9 lo_oe on", lo_oe, 1);
        chk("R9 lo byte", lo_byte, 8'h77);
        chk("R8 hi off", {hi_oe, hi_byte}, 0);
        lo_en_n = 1'b1;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_track();
        t_busy_hold();
        t_inhibit_idle();
        t_inhibit_busy();
        t_bytes();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule